// File: doc/BRIEF.md
# Multi-write output port cell queue

This block is the cell queue that sits behind one output of a square N×N cell switch whose interconnection network runs with an output speed-up of K. Time is divided into slots, and a slot strobe marks the clock cycle in which a slot's transfers take effect. In that cycle the fabric may offer up to K fixed-size cells on K parallel write lanes, while the output line can take at most one cell. The queue keeps up to `DEPTH` cells and sends them out strictly in the order they were stored.

Cells that arrive in the same slot are stored by lane number, lowest first. When the free space cannot hold every offered cell, the lowest-numbered valid lanes are taken until the space runs out. The remaining lanes are refused through an accept mask that is driven combinationally in the same cycle. A cell that leaves in the slot makes room for arrivals in that same slot, but only when the output line is ready. With `DEPTH` set to zero there is no storage, K must be 1, and the cell on lane 0 goes straight to the output.

Top module: `egress_cell_queue`

## Requirements
- R1: In a slot cycle every valid lane is accepted when the free space allows it. Accepted cells are stored in ascending lane order, lane 0 first.
- R2: `out_valid` is high exactly when the queue holds at least one cell. One cell leaves per slot cycle in which `out_valid` and `out_ready` are both high, and no cell leaves in any other cycle.
- R3: Cells leave in the same order in which they were stored, across slots and within a slot.
- R4: When the valid lanes outnumber the free space, the lowest-numbered valid lanes are accepted up to the free space. The rest see `wr_accept` low in that same cycle, bit i of `wr_accept` belonging to lane i.
- R5: The free space for a slot is `DEPTH` minus the occupancy, plus one if a cell departs in that slot (`out_valid` and `out_ready` high). A full queue with `out_ready` low accepts nothing. A full queue with `out_ready` high accepts exactly one cell.
- R6: `occupancy` reports the stored cell count, from 0 to `DEPTH`. `full` (count equal to `DEPTH`) and `empty` (count zero) are registered, and all three change at the clock edge that ends a slot.
- R7: A synchronous active-high `rst` empties the queue. After it, `occupancy` is 0, `empty` is 1, `full` is 0 and `out_valid` is 0.
- R8: In a cycle with `slot_tick` low no lane is accepted and no cell leaves, whatever `wr_valid` and `out_ready` show.
- R9: The configuration must satisfy K ≤ min(DEPTH, N) with N a power of 2, and any other configuration is refused at elaboration. With `DEPTH` = 0 (and then K = 1), lane 0 is passed straight through: `out_valid` = `slot_tick` & `wr_valid[0]`, `out_data` = lane 0 data, `wr_accept[0]` = that valid & `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | Marks the cycle in which a slot's transfers happen |
| wr_valid | input | SPEEDUP | Per-lane cell offered by the fabric |
| wr_data | input | SPEEDUP*CELL_W | Lane cells, lane i at bits i*CELL_W upward |
| wr_accept | output | SPEEDUP | Per-lane acceptance, valid in the same cycle |
| out_valid | output | 1 | A cell is at the head of the queue |
| out_ready | input | 1 | Output line can take the head cell |
| out_data | output | CELL_W | Head cell |
| occupancy | output | clog2(DEPTH+1), at least 1 | Stored cell count |
| full | output | 1 | Registered full flag |
| empty | output | 1 | Registered empty flag |

## Verification
`wr_accept` is combinational, so the bench reads it in the same cycle it drives a slot, after the departure of that slot has been taken out of its model. `occupancy`, `full`, `empty`, `out_valid` and `out_data` reflect a slot one edge later, so the monitor compares them in the low phase of the next cycle against a reference queue that has all arrivals up to the previous slot. The pass-through variant has no registers, so its outputs are checked in the same low phase in which its inputs are driven.

// File: rtl/oq_pkg.sv
package oq_pkg;
  typedef int unsigned idx_t;

  // width able to hold values 0..v-1, never below one bit
  function automatic int cnt_bits(input int v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

  // circular pointer advance for a buffer that need not be a power of two
  function automatic idx_t wrap_add(input idx_t base, input idx_t step, input idx_t depth);
    idx_t sum;
    sum = base + step;
    return (sum >= depth) ? sum - depth : sum;
  endfunction

  // room available to this slot's arrivals, counting a same-slot departure
  function automatic idx_t slot_room(input idx_t depth, input idx_t count, input logic dep);
    return depth - count + (dep ? 1 : 0);
  endfunction
endpackage

// File: rtl/oq_lane_pick.sv
module oq_lane_pick
  import oq_pkg::*;
#(
  parameter int SPEEDUP = 4,
  parameter int CNT_W   = 5,
  localparam int OFF_W  = cnt_bits(SPEEDUP)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SPEEDUP-1:0]         lane_req,
  input  logic [CNT_W-1:0]           room,
  output logic [SPEEDUP-1:0]         lane_take,
  output logic [SPEEDUP*OFF_W-1:0]   lane_off
);
  logic [CNT_W-1:0] taken;

  always_comb begin
    taken     = '0;
    lane_take = '0;
    lane_off  = '0;
    for (int i = 0; i < SPEEDUP; i++) begin
      if (lane_req[i] && (taken < room)) begin
        lane_take[i]               = 1'b1;
        lane_off[i*OFF_W +: OFF_W] = taken[OFF_W-1:0];
        taken                      = taken + 1'b1;
      end
    end
  end

  // R4
  accept_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_take & ~lane_req) == '0);

  // R4
  accept_room_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_take) <= int'(room));

  for (genvar g = 0; g < SPEEDUP; g++) begin : g_order
    // R1
    lane_order_chk: assert property (@(posedge clk) disable iff (rst)
      (lane_req[g] && !lane_take[g]) |-> ((lane_take >> g) == '0));
  end
endmodule

// File: rtl/oq_ring.sv
module oq_ring
  import oq_pkg::*;
#(
  parameter int SPEEDUP = 4,
  parameter int DEPTH   = 16,
  parameter int CELL_W  = 16,
  localparam int CNT_W  = cnt_bits(DEPTH + 1),
  localparam int PTR_W  = cnt_bits(DEPTH),
  localparam int OFF_W  = cnt_bits(SPEEDUP)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SPEEDUP-1:0]         wr_en,
  input  logic [SPEEDUP*OFF_W-1:0]   wr_off,
  input  logic [SPEEDUP*CELL_W-1:0]  wr_cells,
  input  logic                       pop,
  output logic [CELL_W-1:0]          head,
  output logic [CNT_W-1:0]           count,
  output logic [CNT_W-1:0]           count_next
);
  logic [CELL_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  n_push;

  always_comb begin
    n_push     = CNT_W'($countones(wr_en));
    count_next = count + n_push - CNT_W'(pop);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SPEEDUP; i++) begin
      if (wr_en[i])
        mem[PTR_W'(wrap_add(idx_t'(wr_ptr), idx_t'(wr_off[i*OFF_W +: OFF_W]), idx_t'(DEPTH)))]
          <= wr_cells[i*CELL_W +: CELL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= PTR_W'(wrap_add(idx_t'(wr_ptr), idx_t'(n_push), idx_t'(DEPTH)));
      if (pop)
        rd_ptr <= PTR_W'(wrap_add(idx_t'(rd_ptr), 1, idx_t'(DEPTH)));
      count <= count_next;
    end
  end

  assign head = mem[rd_ptr];

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);

  // R2
  pop_has_cell_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/egress_cell_queue.sv
module egress_cell_queue
  import oq_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int SPEEDUP = 4,
  parameter int DEPTH   = 16,
  parameter int CELL_W  = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               slot_tick,
  input  logic [SPEEDUP-1:0]                 wr_valid,
  input  logic [SPEEDUP*CELL_W-1:0]          wr_data,
  output logic [SPEEDUP-1:0]                 wr_accept,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [CELL_W-1:0]                  out_data,
  output logic [cnt_bits(DEPTH+1)-1:0]       occupancy,
  output logic                               full,
  output logic                               empty
);
  localparam int CNT_W  = cnt_bits(DEPTH + 1);
  localparam int OFF_W  = cnt_bits(SPEEDUP);
  localparam bit PORTS_POW2 = (N_PORTS >= 1) && ((N_PORTS & (N_PORTS - 1)) == 0);
  localparam bit SPEED_OK   = (SPEEDUP >= 1) && (SPEEDUP <= N_PORTS) &&
                              ((DEPTH == 0) ? (SPEEDUP == 1) : (SPEEDUP <= DEPTH));

  // R9: configuration rule
  if (!PORTS_POW2 || !SPEED_OK || DEPTH < 0) begin : g_bad_cfg
    $error("egress_cell_queue: need N_PORTS power of 2 and SPEEDUP <= min(DEPTH, N_PORTS)");
  end

  if (DEPTH == 0) begin : g_thru
    // R9: no storage, lane 0 forwarded
    always_comb begin
      out_valid    = slot_tick & wr_valid[0];
      out_data     = wr_data[CELL_W-1:0];
      wr_accept    = '0;
      wr_accept[0] = slot_tick & wr_valid[0] & out_ready;
      occupancy    = '0;
      full         = 1'b1;
      empty        = 1'b1;
    end
  end else begin : g_queue
    logic [SPEEDUP-1:0]       lane_req;
    logic [SPEEDUP*OFF_W-1:0] lane_off;
    logic [CNT_W-1:0]         room;
    logic [CNT_W-1:0]         cnt_next;
    logic                     depart;
    logic                     full_q, empty_q;

    assign lane_req = wr_valid & {SPEEDUP{slot_tick}};
    assign depart   = slot_tick & out_valid & out_ready;
    assign room     = slot_tick ? CNT_W'(slot_room(idx_t'(DEPTH), idx_t'(occupancy), depart)) : '0;

    oq_lane_pick #(.SPEEDUP(SPEEDUP), .CNT_W(CNT_W)) u_pick (
      .clk       (clk),
      .rst       (rst),
      .lane_req  (lane_req),
      .room      (room),
      .lane_take (wr_accept),
      .lane_off  (lane_off)
    );

    oq_ring #(.SPEEDUP(SPEEDUP), .DEPTH(DEPTH), .CELL_W(CELL_W)) u_ring (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_accept),
      .wr_off     (lane_off),
      .wr_cells   (wr_data),
      .pop        (depart),
      .head       (out_data),
      .count      (occupancy),
      .count_next (cnt_next)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end else begin
        full_q  <= (int'(cnt_next) == DEPTH);
        empty_q <= (cnt_next == '0);
      end
    end

    assign full      = full_q;
    assign empty     = empty_q;
    assign out_valid = ~empty_q;

    // R5
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
      (full && !out_ready) |-> (wr_accept == '0));

    // R8
    idle_no_take_chk: assert property (@(posedge clk) disable iff (rst)
      !slot_tick |-> (wr_accept == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !slot_tick |=> $stable(occupancy));

    // R6
    flag_match_chk: assert property (@(posedge clk) disable iff (rst)
      (full == (int'(occupancy) == DEPTH)) && (empty == (occupancy == '0)));
  end
endmodule

// File: tb/egress_cell_queue_bench.sv
module egress_cell_queue_bench;
  localparam int PORTS = 8;
  localparam int K     = 4;
  localparam int DEPTH = 16;
  localparam int CW    = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst = 1'b1;
  logic            slot_tick = 1'b0;
  logic [K-1:0]    wr_valid = '0;
  logic [K*CW-1:0] wr_data = '0;
  logic            out_ready = 1'b0;
  logic [K-1:0]    wr_accept;
  logic            out_valid;
  logic [CW-1:0]   out_data;
  logic [4:0]      occupancy;
  logic            full, empty;

  egress_cell_queue #(.N_PORTS(PORTS), .SPEEDUP(K), .DEPTH(DEPTH), .CELL_W(CW)) u_egress_cell_queue (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_accept(wr_accept), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .occupancy(occupancy), .full(full), .empty(empty));

  // pass-through variant
  logic          t_tick = 1'b0, t_valid = 1'b0, t_ready = 1'b0;
  logic [CW-1:0] t_data = '0;
  logic [0:0]    t_accept, t_occ;
  logic          t_out_valid, t_full, t_empty;
  logic [CW-1:0] t_out_data;

  egress_cell_queue #(.N_PORTS(PORTS), .SPEEDUP(1), .DEPTH(0), .CELL_W(CW)) u_egress_cell_queue_thru (
    .clk(clk), .rst(rst), .slot_tick(t_tick), .wr_valid(t_valid), .wr_data(t_data),
    .wr_accept(t_accept), .out_valid(t_out_valid), .out_ready(t_ready), .out_data(t_out_data),
    .occupancy(t_occ), .full(t_full), .empty(t_empty));

  int total = 0;
  int bad   = 0;
  logic [CW-1:0] exp_q[$];
  logic [CW-1:0] seq = 16'h0100;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares registered outputs and pops the reference queue
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      check(int'(occupancy) == exp_q.size(), "R6 occupancy", int'(occupancy), exp_q.size());
      check(empty == (exp_q.size() == 0), "R6 empty", int'(empty), int'(exp_q.size() == 0));
      check(full == (exp_q.size() == DEPTH), "R6 full", int'(full), int'(exp_q.size() == DEPTH));
      check(out_valid == (exp_q.size() != 0), "R2 out_valid", int'(out_valid), int'(exp_q.size() != 0));
      if (slot_tick && out_ready && exp_q.size() > 0) begin
        check(out_data == exp_q[0], "R3 order", int'(out_data), int'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
  end

  // driver: one slot per call, predicts the accept mask and pushes accepted cells
  task automatic run_slot(input logic tick, input logic [K-1:0] v, input logic rdy, input string tag);
    logic [K-1:0] expm;
    int taken;
    int room;
    @(negedge clk);
    slot_tick = tick;
    wr_valid  = v;
    out_ready = rdy;
    for (int i = 0; i < K; i++) begin
      wr_data[i*CW +: CW] = seq;
      seq = seq + 1'b1;
    end
    #2;
    room  = DEPTH - exp_q.size();
    expm  = '0;
    taken = 0;
    for (int i = 0; i < K; i++) begin
      if (tick && v[i] && taken < room) begin
        expm[i] = 1'b1;
        taken++;
      end
    end
    check(wr_accept == expm, tag, int'(wr_accept), int'(expm));
    for (int i = 0; i < K; i++)
      if (expm[i]) exp_q.push_back(wr_data[i*CW +: CW]);
  endtask

  task automatic check_reset_state();
    check(occupancy == '0, "R7 occupancy", int'(occupancy), 0);
    check(empty == 1'b1, "R7 empty", int'(empty), 1);
    check(full == 1'b0, "R7 full", int'(full), 0);
    check(out_valid == 1'b0, "R7 out_valid", int'(out_valid), 0);
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_reset_state();
    rst = 1'b0;

    // R1: arrivals with room to spare, various lane patterns
    run_slot(1'b1, 4'b1111, 1'b0, "R1 all lanes");
    run_slot(1'b1, 4'b1010, 1'b0, "R1 odd lanes");
    run_slot(1'b1, 4'b0110, 1'b0, "R1 middle lanes");
    run_slot(1'b1, 4'b1111, 1'b0, "R1 all lanes");
    // R4: room 4, three offered; then room 1, lowest valid lane wins
    run_slot(1'b1, 4'b1101, 1'b0, "R4 fits");
    run_slot(1'b1, 4'b1110, 1'b0, "R4 partial refuse");
    run_slot(1'b1, 4'b1111, 1'b0, "R4 full refuse");
    // R5: full, departure frees one place only with ready
    run_slot(1'b1, 4'b0011, 1'b1, "R5 full with departure");
    run_slot(1'b1, 4'b1100, 1'b1, "R5 full with departure");
    run_slot(1'b1, 4'b1111, 1'b0, "R5 full no ready");
    // R8: no slot strobe, nothing taken, nothing leaves
    run_slot(1'b0, 4'b1111, 1'b1, "R8 idle");
    run_slot(1'b0, 4'b0001, 1'b1, "R8 idle");
    // R2/R3: drain with sparse arrivals
    for (int s = 0; s < 8; s++) run_slot(1'b1, 4'b0000, 1'b1, "R2 drain");
    for (int s = 0; s < 6; s++) run_slot(1'b1, 4'b0101, 1'b1, "R3 mixed");
    for (int s = 0; s < 24; s++) run_slot(1'b1, 4'b0000, 1'b1, "R2 drain");
    run_slot(1'b1, 4'b1000, 1'b1, "R1 single high lane");
    run_slot(1'b1, 4'b0000, 1'b0, "R2 hold");
    run_slot(1'b1, 4'b1011, 1'b0, "R1 refill");

    // R7: reset with cells stored
    @(negedge clk);
    slot_tick = 1'b0;
    wr_valid  = '0;
    rst       = 1'b1;
    exp_q.delete();
    @(negedge clk);
    #1;
    check_reset_state();
    rst = 1'b0;
    run_slot(1'b1, 4'b0011, 1'b1, "R1 after reset");
    run_slot(1'b1, 4'b0000, 1'b1, "R2 after reset");
    run_slot(1'b1, 4'b0000, 1'b1, "R2 after reset");
    run_slot(1'b0, 4'b0000, 1'b0, "R8 stop");

    // R9: pass-through variant
    @(negedge clk);
    t_tick = 1'b1; t_valid = 1'b1; t_ready = 1'b1; t_data = 16'hBEEF;
    #1;
    check(t_out_valid == 1'b1, "R9 thru valid", int'(t_out_valid), 1);
    check(t_out_data == 16'hBEEF, "R9 thru data", int'(t_out_data), 16'hBEEF);
    check(t_accept == 1'b1, "R9 thru accept", int'(t_accept), 1);
    @(negedge clk);
    t_ready = 1'b0; t_data = 16'h1234;
    #1;
    check(t_accept == 1'b0, "R9 thru stalled", int'(t_accept), 0);
    check(t_out_data == 16'h1234, "R9 thru data", int'(t_out_data), 16'h1234);
    @(negedge clk);
    t_tick = 1'b0; t_ready = 1'b1;
    #1;
    check(t_out_valid == 1'b0, "R9 thru idle", int'(t_out_valid), 0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule